// File: doc/BRIEF.md
# Seven-Stage Pseudo-Random Bit Source

This block produces a repeating pseudo-random bit stream from a seven-stage serial shift register. Each enabled clock moves the register one place toward the last stage. The new first-stage bit is the equality (XNOR) of stages six and seven. Because the feedback is an equality gate, the cleared all-zero register is a legal member of the sequence. The only state the register can stick in is all ones, and the block steps out of that state by loading zeros.

A typical use is as a stimulus source for an encoder or decoder under test. The consumer takes either the serial bit from stage seven or the whole parallel state. A synchronous clear restarts the stream from zero at a known point, and the shift enable lets the consumer pace the stream.

Top module: `prbs7_gen`

## Requirements
- R1: While rst_ni is low the state is the parameter RST_STATE, which is all zeros by default, and state_o shows it.
- R2: clear_i is synchronous. A clock edge with clear_i high sets all seven stages to 0, whatever the value of shift_en_i.
- R3: On an edge with shift_en_i high, clear_i low and a state other than all ones, the new state_o is {old[5:0], ~(old[5] ^ old[6])}. Stage 1 is bit 0 and stage 7 is bit 6.
- R4: On an edge with shift_en_i low and clear_i low, state_o keeps its value.
- R5: serial_o always equals state_o[6], the stage-7 output.
- R6: Starting from all zeros, 127 consecutive shifts pass through 127 distinct states, and the register is back at all zeros after exactly the 127th shift.
- R7: After a clear, state_o never equals 7'h7F, however many shifts follow.
- R8: On an edge with shift_en_i high, clear_i low and state_o equal to 7'h7F, the next state is 7'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear to all zeros; takes priority over shift_en_i |
| shift_en_i | input | 1 | Advances the register by one stage per clock |
| serial_o | output | 1 | Serial bit, taken from stage 7 |
| state_o | output | 7 | Parallel state; stage 1 is bit 0 |

## Verification
The lockup escape is the hard case to reach. The all-ones state lies outside the sequence, so neither a clear nor any number of shifts will ever produce it. The bench therefore adds a second instance whose RST_STATE parameter is all ones. That instance starts in the lockup state straight out of reset, so the bench can check that it holds while disabled and returns to zero on its first enabled shift. The first instance is walked through two complete periods to confirm that every state is distinct and that all ones never appears.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;
  localparam int unsigned PRBS_WIDTH = 7;
  localparam int unsigned PRBS_TAP_A = 6;  // 1-based stage numbers
  localparam int unsigned PRBS_TAP_B = 7;
  localparam int unsigned PRBS_PERIOD = (1 << PRBS_WIDTH) - 1;
endpackage

// File: rtl/prbs7_feedback.sv
module prbs7_feedback #(
  parameter int unsigned WIDTH = prbs7_pkg::PRBS_WIDTH,
  parameter int unsigned TAP_A = prbs7_pkg::PRBS_TAP_A,
  parameter int unsigned TAP_B = prbs7_pkg::PRBS_TAP_B
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o,
  output logic             lock_o
);
  // equality feedback: all-zero state is legal, all-ones is the stuck state
  assign fb_o   = ~(state_i[TAP_A-1] ^ state_i[TAP_B-1]);
  assign lock_o = &state_i;
endmodule

// File: rtl/prbs7_shift_reg.sv
module prbs7_shift_reg #(
  parameter int unsigned     WIDTH     = prbs7_pkg::PRBS_WIDTH,
  parameter logic [WIDTH-1:0] RST_STATE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic             fb_i,
  input  logic             lock_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clear_i)     q_d = '0;
    else if (en_i)   q_d = lock_i ? '0 : {q_q[WIDTH-2:0], fb_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_STATE;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  assert_clear_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (q_o == '0));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !en_i) |=> $stable(q_o));
  assert_lock_escape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && en_i && lock_i) |=> (q_o == '0));
endmodule

// File: rtl/prbs7_gen.sv
module prbs7_gen #(
  parameter int unsigned      WIDTH     = prbs7_pkg::PRBS_WIDTH,
  parameter int unsigned      TAP_A     = prbs7_pkg::PRBS_TAP_A,
  parameter int unsigned      TAP_B     = prbs7_pkg::PRBS_TAP_B,
  parameter logic [WIDTH-1:0] RST_STATE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             shift_en_i,
  output logic             serial_o,
  output logic [WIDTH-1:0] state_o
);
  logic fb, lock;

  prbs7_feedback #(.WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_fb (
    .state_i(state_o), .fb_o(fb), .lock_o(lock)
  );

  prbs7_shift_reg #(.WIDTH(WIDTH), .RST_STATE(RST_STATE)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .en_i(shift_en_i),
    .fb_i(fb), .lock_i(lock), .q_o(state_o)
  );

  assign serial_o = state_o[WIDTH-1];

  assert_shift_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !clear_i && !(&state_o)) |=>
      (state_o == {$past(state_o[WIDTH-2:0]),
                   ~($past(state_o[TAP_A-1]) ^ $past(state_o[TAP_B-1]))}));
  assert_lock_escape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_en_i && !clear_i && (&state_o)) |=> (state_o == '0));
endmodule

// File: tb/test_prbs7_gen.sv
module test_prbs7_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, en = 1'b0, en_l = 1'b0;
  logic ser, ser_l;
  logic [6:0] st, st_l;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prbs7_gen i_prbs7_gen (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clr), .shift_en_i(en),
    .serial_o(ser), .state_o(st)
  );

  prbs7_gen #(.RST_STATE(7'h7F)) i_prbs7_gen_lock (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(1'b0), .shift_en_i(en_l),
    .serial_o(ser_l), .state_o(st_l)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] model_next(input logic [6:0] s);
    return {s[5:0], ~(s[5] ^ s[6])};
  endfunction

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic t_reset();
    check(st == 7'h00, "R1", st, 0);
    check(ser == 1'b0, "R5", ser, 0);
    check(st_l == 7'h7F, "R1", st_l, 7'h7F);
  endtask

  task automatic t_hold();
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check(st == 7'h00, "R4", st, 0);
    end
  endtask

  task automatic t_full_period();
    bit [127:0] seen = '0;
    logic [6:0] exp_s = st;
    seen[st] = 1'b1;
    en = 1'b1;
    for (int i = 1; i <= 127; i++) begin
      tick();
      exp_s = model_next(exp_s);
      check(st == exp_s, "R3", st, exp_s);
      check(ser == st[6], "R5", ser, st[6]);
      check(st != 7'h7F, "R7", st, 0);
      if (i < 127) begin
        check(!seen[st], "R6", st, 0);
        seen[st] = 1'b1;
      end
    end
    check(st == 7'h00, "R6", st, 0);
    en = 1'b0;
  endtask

  task automatic t_clear_priority();
    en = 1'b1;
    for (int i = 0; i < 9; i++) tick();
    check(st != 7'h00, "R3", st, 1);
    clr = 1'b1;
    tick();
    check(st == 7'h00, "R2", st, 0);
    clr = 1'b0;
    en = 1'b0;
    tick();
    check(st == 7'h00, "R4", st, 0);
  endtask

  task automatic t_no_lockup();
    int ones = 0;
    en = 1'b1;
    for (int i = 0; i < 254; i++) begin
      tick();
      if (st == 7'h7F) ones++;
    end
    check(ones == 0, "R7", ones, 0);
    check(st == 7'h00, "R6", st, 0);
    en = 1'b0;
  endtask

  task automatic t_lock_escape();
    en_l = 1'b0;
    tick();
    check(st_l == 7'h7F, "R4", st_l, 7'h7F);
    en_l = 1'b1;
    tick();
    check(st_l == 7'h00, "R8", st_l, 0);
    check(ser_l == 1'b0, "R5", ser_l, 0);
    tick();
    check(st_l == 7'h01, "R3", st_l, 1);
    en_l = 1'b0;
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    t_hold();
    t_full_period();
    t_clear_priority();
    t_no_lockup();
    t_lock_escape();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule